// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Least-Recently-Used Replacement

This block caches virtual-to-physical page mappings in a small set of fully associative slots. A lookup presents a virtual address with its access kind (read or write), the current privilege level and the write-protect control bit. In the same cycle the block reports whether a slot matched, the physical address, the slot's uncacheable flag and whether the access breaks the page's permissions. Each slot keeps its own page-size exponent, so small and large pages can sit side by side.

New mappings arrive on an insert port. A page that is already cached is rewritten in its existing slot. Otherwise the lowest-numbered free slot is filled, or, when every slot is in use, the slot with the oldest use stamp is replaced. Stamps come from a shared counter that advances on every insert and on every lookup that asks to refresh its slot. Maintenance inputs clear the whole buffer, clear only the slots not marked global, or drop the single page that covers a given address.

Top module: `tlb_fa`

## Requirements
- R1: After reset every slot is empty, and any lookup reports a miss.
- R2: `lk_hit` is 1 in the same cycle as a lookup that falls inside a valid slot's page, and 0 whenever `lk_valid` is 0. On a hit, `lk_pa` is the slot's physical base ORed with the bits of `lk_va` below the slot's page-size exponent, and `lk_uncached` equals the slot's uncacheable flag.
- R3: An insert of an absent page uses the lowest-numbered free slot if one exists. If none is free, it replaces the slot with the smallest use stamp.
- R4: An insert stamps its slot with the counter value, and so does a hit lookup with `lk_touch`=1; each stamping advances the counter by one. A hit lookup with `lk_touch`=0 leaves every stamp unchanged.
- R5: An insert whose address falls inside an already cached page rewrites that slot in place and allocates no second slot.
- R6: `flush_all` empties every slot.
- R7: `flush_nonglobal` empties exactly the slots whose global flag is 0.
- R8: `inval_valid` empties the slot whose page covers `inval_va`, if there is one, and changes no other slot.
- R9: An access is a user access when `lk_cpl` equals 3. A user access to a hit slot whose user flag is 0 sets `lk_fault`.
- R10: A write (`lk_write`=1) to a hit slot whose writable flag is 0 sets `lk_fault` when it is a user access or when `lk_wp`=1. `lk_fault` is never 1 without `lk_hit`.
- R11: At most one command acts per cycle, in the priority order flush_all, flush_nonglobal, inval, insert; a lower-priority command asserted in the same cycle is ignored. A lookup refresh is ignored in any cycle that carries a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Lookup virtual address |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_cpl | input | 2 | Current privilege level (3 = user) |
| lk_wp | input | 1 | Write-protect control bit |
| lk_touch | input | 1 | Refresh the hit slot's use stamp |
| lk_hit | output | 1 | Lookup matched a valid slot |
| lk_pa | output | PA_W | Translated physical address (0 on miss) |
| lk_uncached | output | 1 | Uncacheable flag of the hit slot |
| lk_fault | output | 1 | Permission fault on the hit slot |
| ins_valid | input | 1 | Insert request |
| ins_va | input | VA_W | Virtual address of the new page |
| ins_pa | input | PA_W | Physical base of the new page |
| ins_log | input | LOG_W | Page-size exponent of the new page |
| ins_writable | input | 1 | Page is writable |
| ins_user | input | 1 | Page is accessible at user level |
| ins_global | input | 1 | Page survives flush_nonglobal |
| ins_uncached | input | 1 | Page is uncacheable |
| flush_all | input | 1 | Empty every slot |
| flush_nonglobal | input | 1 | Empty every non-global slot |
| inval_valid | input | 1 | Drop the page covering inval_va |
| inval_va | input | VA_W | Address whose page is dropped |

## Verification
The assertions assume that no two valid slots ever cover the same address: the count-based properties for insert and invalidate rely on a single match. This holds as long as pages of different sizes are never inserted over one another. The random phase therefore draws only small pages from a pool of twelve addresses, and the single large page is used only in directed steps on a disjoint region. The pool is larger than the slot count, which forces steady replacement, and use stamps stay well below counter wrap over the whole run.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;

    // Privilege level that marks a user access
    localparam logic [1:0] CPL_USER = 2'd3;

    // Command acting on the slot array this cycle, after priority resolution
    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_FLUSH_ALL,
        CMD_FLUSH_NG,
        CMD_INVAL,
        CMD_INSERT
    } tlb_cmd_e;

endpackage

// File: rtl/tlb_fa_match.sv
module tlb_fa_match #(
    parameter int VA_W  = 32,
    parameter int LOG_W = 5
) (
    input  logic             e_valid,
    input  logic [VA_W-1:0]  e_vbase,
    input  logic [LOG_W-1:0] e_log,
    input  logic [VA_W-1:0]  va,
    output logic             hit
);
    logic [VA_W-1:0] off_mask;

    // Offset bits of this slot's page are ignored in the compare
    assign off_mask = (VA_W'(1) << e_log) - VA_W'(1);
    assign hit      = e_valid && ((va & ~off_mask) == e_vbase);
endmodule

// File: rtl/tlb_fa_victim.sv
module tlb_fa_victim #(
    parameter int N       = 8,
    parameter int STAMP_W = 16,
    parameter int IDX_W   = 3
) (
    input  logic [N-1:0]              valid,
    input  logic [N-1:0][STAMP_W-1:0] stamps,
    output logic [IDX_W-1:0]          idx
);
    logic               free_found;
    logic [IDX_W-1:0]   free_idx;
    logic [IDX_W-1:0]   old_idx;
    logic [STAMP_W-1:0] old_stamp;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        old_idx    = '0;
        old_stamp  = stamps[0];
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !free_found) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
            if (stamps[i] < old_stamp) begin
                old_stamp = stamps[i];
                old_idx   = IDX_W'(i);
            end
        end
        idx = free_found ? free_idx : old_idx;
    end
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
    import tlb_fa_pkg::*;
#(
    parameter int N       = 8,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int LOG_W   = 5,
    parameter int STAMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             lk_write,
    input  logic [1:0]       lk_cpl,
    input  logic             lk_wp,
    input  logic             lk_touch,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_pa,
    output logic             lk_uncached,
    output logic             lk_fault,
    input  logic             ins_valid,
    input  logic [VA_W-1:0]  ins_va,
    input  logic [PA_W-1:0]  ins_pa,
    input  logic [LOG_W-1:0] ins_log,
    input  logic             ins_writable,
    input  logic             ins_user,
    input  logic             ins_global,
    input  logic             ins_uncached,
    input  logic             flush_all,
    input  logic             flush_nonglobal,
    input  logic             inval_valid,
    input  logic [VA_W-1:0]  inval_va
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    if (N < 1) begin : g_bad_size
        $error("tlb_fa: N must be at least 1");
    end

    typedef struct packed {
        logic               valid;
        logic [VA_W-1:0]    vbase;
        logic [PA_W-1:0]    pbase;
        logic [LOG_W-1:0]   lg;
        logic               wr;
        logic               usr;
        logic               glb;
        logic               unc;
        logic [STAMP_W-1:0] stamp;
    } entry_t;

    typedef struct packed {
        entry_t [N-1:0]     ent;
        logic [STAMP_W-1:0] ctr;
    } state_t;

    state_t s_d, s_q;

    logic [N-1:0]              valid_vec, glb_vec;
    logic [N-1:0][STAMP_W-1:0] stamp_vec;
    logic [N-1:0]              lk_match, ins_match, inv_match;
    logic [IDX_W-1:0]          lk_idx, ins_idx, inv_idx, victim_idx;
    logic                      lk_any, ins_any, inv_any;
    tlb_cmd_e                  cmd;

    for (genvar g = 0; g < N; g++) begin : g_slot
        assign valid_vec[g] = s_q.ent[g].valid;
        assign glb_vec[g]   = s_q.ent[g].glb;
        assign stamp_vec[g] = s_q.ent[g].stamp;

        tlb_fa_match #(.VA_W(VA_W), .LOG_W(LOG_W)) u_lk_match (
            .e_valid(s_q.ent[g].valid), .e_vbase(s_q.ent[g].vbase),
            .e_log(s_q.ent[g].lg), .va(lk_va), .hit(lk_match[g]));
        tlb_fa_match #(.VA_W(VA_W), .LOG_W(LOG_W)) u_ins_match (
            .e_valid(s_q.ent[g].valid), .e_vbase(s_q.ent[g].vbase),
            .e_log(s_q.ent[g].lg), .va(ins_va), .hit(ins_match[g]));
        tlb_fa_match #(.VA_W(VA_W), .LOG_W(LOG_W)) u_inv_match (
            .e_valid(s_q.ent[g].valid), .e_vbase(s_q.ent[g].vbase),
            .e_log(s_q.ent[g].lg), .va(inval_va), .hit(inv_match[g]));
    end

    tlb_fa_victim #(.N(N), .STAMP_W(STAMP_W), .IDX_W(IDX_W)) u_victim (
        .valid(valid_vec), .stamps(stamp_vec), .idx(victim_idx));

    // Lowest matching slot for each of the three compare sets
    always_comb begin
        lk_any = 1'b0;  lk_idx  = '0;
        ins_any = 1'b0; ins_idx = '0;
        inv_any = 1'b0; inv_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (lk_match[i])  begin lk_any  = 1'b1; lk_idx  = IDX_W'(i); end
            if (ins_match[i]) begin ins_any = 1'b1; ins_idx = IDX_W'(i); end
            if (inv_match[i]) begin inv_any = 1'b1; inv_idx = IDX_W'(i); end
        end
    end

    // Lookup result and permission check
    entry_t          hit_e;
    logic [PA_W-1:0] pa_mask;
    logic            user_acc, bad_write;

    always_comb begin
        hit_e       = s_q.ent[lk_idx];
        pa_mask     = (PA_W'(1) << hit_e.lg) - PA_W'(1);
        user_acc    = (lk_cpl == CPL_USER);
        bad_write   = !hit_e.wr && (user_acc || lk_wp);
        lk_hit      = lk_valid && lk_any;
        lk_pa       = lk_hit ? (hit_e.pbase | (PA_W'(lk_va) & pa_mask)) : '0;
        lk_uncached = lk_hit && hit_e.unc;
        lk_fault    = lk_hit && ((user_acc && !hit_e.usr) || (lk_write && bad_write));
    end

    // Command priority
    always_comb begin
        if (flush_all)            cmd = CMD_FLUSH_ALL;
        else if (flush_nonglobal) cmd = CMD_FLUSH_NG;
        else if (inval_valid)     cmd = CMD_INVAL;
        else if (ins_valid)       cmd = CMD_INSERT;
        else                      cmd = CMD_NONE;
    end

    // Next state
    logic [IDX_W-1:0]  tgt;
    logic [VA_W-1:0]   ins_mask;

    always_comb begin
        s_d      = s_q;
        tgt      = ins_any ? ins_idx : victim_idx;
        ins_mask = (VA_W'(1) << ins_log) - VA_W'(1);
        unique case (cmd)
            CMD_FLUSH_ALL: begin
                for (int i = 0; i < N; i++) s_d.ent[i].valid = 1'b0;
            end
            CMD_FLUSH_NG: begin
                for (int i = 0; i < N; i++)
                    if (!s_q.ent[i].glb) s_d.ent[i].valid = 1'b0;
            end
            CMD_INVAL: begin
                if (inv_any) s_d.ent[inv_idx].valid = 1'b0;
            end
            CMD_INSERT: begin
                s_d.ent[tgt].valid = 1'b1;
                s_d.ent[tgt].vbase = ins_va & ~ins_mask;
                s_d.ent[tgt].pbase = ins_pa;
                s_d.ent[tgt].lg    = ins_log;
                s_d.ent[tgt].wr    = ins_writable;
                s_d.ent[tgt].usr   = ins_user;
                s_d.ent[tgt].glb   = ins_global;
                s_d.ent[tgt].unc   = ins_uncached;
                s_d.ent[tgt].stamp = s_q.ctr;
                s_d.ctr            = s_q.ctr + STAMP_W'(1);
            end
            default: begin
                if (lk_valid && lk_touch && lk_any) begin
                    s_d.ent[lk_idx].stamp = s_q.ctr;
                    s_d.ctr               = s_q.ctr + STAMP_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Properties
    assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0));

    assert_flush_ng_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_all && flush_nonglobal) |=> ((valid_vec & ~glb_vec) == '0));

    // R10: a fault is only reported on a hit
    assert_fault_needs_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    assert_probe_keeps_stamps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NONE && !(lk_valid && lk_touch)) |=> $stable(stamp_vec));

    assert_insert_fills_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_INSERT && !ins_any && !(&valid_vec))
        |=> ($countones(valid_vec) == $past($countones(valid_vec)) + 1));

    assert_overwrite_in_place_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_INSERT && ins_any)
        |=> ($countones(valid_vec) == $past($countones(valid_vec))));

    assert_inval_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_INVAL && inv_any)
        |=> ($countones(valid_vec) == $past($countones(valid_vec)) - 1));
endmodule

// File: tb/tlb_fa_bench.sv
module tlb_fa_bench;
    localparam int N = 8, VA_W = 32, PA_W = 32, LOG_W = 5, STAMP_W = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic lk_valid = 0, lk_write = 0, lk_wp = 0, lk_touch = 0;
    logic [VA_W-1:0] lk_va = '0, ins_va = '0, inval_va = '0;
    logic [1:0] lk_cpl = '0;
    logic lk_hit, lk_uncached, lk_fault;
    logic [PA_W-1:0] lk_pa, ins_pa = '0;
    logic [LOG_W-1:0] ins_log = '0;
    logic ins_valid = 0, ins_writable = 0, ins_user = 0, ins_global = 0, ins_uncached = 0;
    logic flush_all = 0, flush_nonglobal = 0, inval_valid = 0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tlb_fa #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .LOG_W(LOG_W), .STAMP_W(STAMP_W)) u_tlb_fa (
        .clk, .rst_n, .lk_valid, .lk_va, .lk_write, .lk_cpl, .lk_wp, .lk_touch,
        .lk_hit, .lk_pa, .lk_uncached, .lk_fault,
        .ins_valid, .ins_va, .ins_pa, .ins_log, .ins_writable, .ins_user,
        .ins_global, .ins_uncached, .flush_all, .flush_nonglobal, .inval_valid, .inval_va);

    // Reference model
    logic [N-1:0] m_v, m_w, m_u, m_g, m_c;
    logic [VA_W-1:0] m_va [N];
    logic [PA_W-1:0] m_pa [N];
    logic [LOG_W-1:0] m_lg [N];
    int unsigned m_st [N];
    int unsigned m_ctr;

    function automatic logic [31:0] low_mask(input logic [LOG_W-1:0] lg);
        return (32'd1 << lg) - 32'd1;
    endfunction

    function automatic int find(input logic [VA_W-1:0] va);
        for (int i = 0; i < N; i++)
            if (m_v[i] && ((va & ~low_mask(m_lg[i])) == m_va[i])) return i;
        return -1;
    endfunction

    function automatic int victim();
        int best = 0;
        for (int i = 0; i < N; i++) if (!m_v[i]) return i;
        for (int i = 1; i < N; i++) if (m_st[i] < m_st[best]) best = i;
        return best;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        int k;
        logic ef;
        k = lk_valid ? find(lk_va) : -1;
        chk("R2 hit", lk_hit, k >= 0);
        if (k >= 0) begin
            chk("R2 pa", lk_pa, m_pa[k] | (lk_va & low_mask(m_lg[k])));
            chk("R2 uncached", lk_uncached, m_c[k]);
            ef = ((lk_cpl == 2'd3) && !m_u[k]) ||
                 (lk_write && !m_w[k] && ((lk_cpl == 2'd3) || lk_wp));
            chk("R9 R10 fault", lk_fault, ef);
        end
    endtask

    task automatic model_update();
        int k;
        if (flush_all) m_v = '0;
        else if (flush_nonglobal) m_v = m_v & m_g;
        else if (inval_valid) begin
            k = find(inval_va);
            if (k >= 0) m_v[k] = 1'b0;
        end else if (ins_valid) begin
            k = find(ins_va);
            if (k < 0) k = victim();
            m_v[k] = 1'b1; m_va[k] = ins_va & ~low_mask(ins_log);
            m_pa[k] = ins_pa; m_lg[k] = ins_log; m_w[k] = ins_writable;
            m_u[k] = ins_user; m_g[k] = ins_global; m_c[k] = ins_uncached;
            m_st[k] = m_ctr; m_ctr++;
        end else if (lk_valid && lk_touch) begin
            k = find(lk_va);
            if (k >= 0) begin m_st[k] = m_ctr; m_ctr++; end
        end
    endtask

    // One cycle: inputs already driven after a falling edge
    task automatic step();
        #2;
        compare_model();
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic idle();
        lk_valid = 0; lk_touch = 0; lk_write = 0; lk_cpl = 0; lk_wp = 0;
        ins_valid = 0; flush_all = 0; flush_nonglobal = 0; inval_valid = 0;
    endtask

    task automatic insert(input logic [31:0] va, input logic [31:0] pa, input int lg,
                          input bit w, input bit u, input bit g, input bit c);
        idle();
        ins_valid = 1; ins_va = va; ins_pa = pa; ins_log = LOG_W'(lg);
        ins_writable = w; ins_user = u; ins_global = g; ins_uncached = c;
        step();
        idle();
    endtask

    // Drive a lookup, return what the design reports at the sample point
    task automatic look(input logic [31:0] va, input bit wr, input logic [1:0] cpl,
                        input bit wp, input bit touch, output bit hit, output bit flt,
                        output logic [31:0] pa);
        idle();
        lk_valid = 1; lk_va = va; lk_write = wr; lk_cpl = cpl; lk_wp = wp; lk_touch = touch;
        #2;
        hit = lk_hit; flt = lk_fault; pa = lk_pa;
        #(-2 + 2);
        compare_model();
        @(posedge clk);
        model_update();
        @(negedge clk);
        idle();
    endtask

    function automatic logic [31:0] pg(input int p);
        return 32'h0001_0000 + (p << 12);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit h, f;
        logic [31:0] pa;
        m_v = '0; m_ctr = 0;
        for (int i = 0; i < N; i++) m_st[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: empty after reset
        look(pg(0), 0, 0, 0, 1, h, f, pa);
        chk("R1 miss after reset", h, 0);

        // Fill all slots; pages 2 and 3 global
        for (int p = 0; p < N; p++)
            insert(pg(p) + 32'h123, 32'h8000_0000 + (p << 12), 12, 1, 1, (p == 2 || p == 3), p[0]);
        look(pg(5) + 32'hABC, 0, 0, 0, 0, h, f, pa);
        chk("R2 hit filled", h, 1);
        chk("R2 pa concat", pa, 32'h8000_5ABC);

        // R3/R4: refresh page 0, probe page 1, insert page 8 -> page 1 replaced
        look(pg(0), 0, 0, 0, 1, h, f, pa);
        look(pg(1), 0, 0, 0, 0, h, f, pa);
        insert(pg(8), 32'h8000_8000, 12, 1, 1, 0, 0);
        look(pg(1), 0, 0, 0, 0, h, f, pa);
        chk("R4 probe did not refresh, R3 oldest replaced", h, 0);
        look(pg(0), 0, 0, 0, 0, h, f, pa);
        chk("R4 refreshed page kept", h, 1);

        // R5: rewrite page 8 in place
        insert(pg(8) + 32'h10, 32'h8100_0000, 12, 1, 1, 0, 0);
        look(pg(8) + 32'h44, 0, 0, 0, 0, h, f, pa);
        chk("R5 new mapping", pa, 32'h8100_0044);
        for (int p = 2; p < N; p++) begin
            look(pg(p), 0, 0, 0, 0, h, f, pa);
            chk("R5 no slot lost", h, 1);
        end

        // R7: keep only global pages 2 and 3
        idle(); flush_nonglobal = 1; step(); idle();
        look(pg(2), 0, 0, 0, 0, h, f, pa); chk("R7 global kept", h, 1);
        look(pg(4), 0, 0, 0, 0, h, f, pa); chk("R7 non-global gone", h, 0);

        // R8: drop page 2 only
        idle(); inval_valid = 1; inval_va = pg(2) + 32'hFFF; step(); idle();
        look(pg(2), 0, 0, 0, 0, h, f, pa); chk("R8 page dropped", h, 0);
        look(pg(3), 0, 0, 0, 0, h, f, pa); chk("R8 other page kept", h, 1);

        // R9/R10 permission cases
        insert(pg(9), 32'h8000_9000, 12, 0, 0, 0, 0);
        look(pg(9), 0, 0, 0, 0, h, f, pa); chk("R9 supervisor read", f, 0);
        look(pg(9), 0, 3, 0, 0, h, f, pa); chk("R9 user to supervisor page", f, 1);
        insert(pg(10), 32'h8000_A000, 12, 0, 1, 0, 1);
        look(pg(10), 1, 3, 0, 0, h, f, pa); chk("R10 user write read-only", f, 1);
        look(pg(10), 1, 0, 0, 0, h, f, pa); chk("R10 supervisor write no wp", f, 0);
        look(pg(10), 1, 0, 1, 0, h, f, pa); chk("R10 supervisor write wp", f, 1);
        look(pg(10), 0, 3, 1, 0, h, f, pa); chk("R9 user read user page", f, 0);

        // R2 large page
        insert(32'h4001_2345, 32'h9000_0000, 16, 1, 1, 0, 1);
        look(32'h4001_ABCD, 0, 0, 0, 0, h, f, pa);
        chk("R2 large page pa", pa, 32'h9000_ABCD);

        // R11: inval with insert -> insert ignored
        idle(); inval_valid = 1; inval_va = pg(3); ins_valid = 1; ins_va = pg(11);
        ins_pa = 32'h8000_B000; ins_log = 12; step(); idle();
        look(pg(11), 0, 0, 0, 0, h, f, pa); chk("R11 insert ignored", h, 0);
        // R6 and R11: flush_all with insert
        idle(); flush_all = 1; ins_valid = 1; ins_va = pg(11); step(); idle();
        look(pg(11), 0, 0, 0, 0, h, f, pa); chk("R6 R11 flush beats insert", h, 0);
        look(pg(10), 0, 0, 0, 0, h, f, pa); chk("R6 all empty", h, 0);

        // Random phase, model compared every cycle
        void'($urandom(32'd1234));
        for (int c = 0; c < 3000; c++) begin
            int r;
            idle();
            r = $urandom_range(0, 99);
            lk_valid = ($urandom_range(0, 9) != 0);
            lk_va = pg($urandom_range(0, 11)) + 32'($urandom_range(0, 4095));
            lk_write = $urandom; lk_cpl = 2'($urandom); lk_wp = $urandom; lk_touch = $urandom;
            ins_va = pg($urandom_range(0, 11)) + 32'($urandom_range(0, 4095));
            ins_pa = {$urandom_range(0, 32'hFFFFF), 12'h0}; ins_log = 12;
            ins_writable = $urandom; ins_user = $urandom; ins_global = $urandom;
            ins_uncached = $urandom;
            inval_va = pg($urandom_range(0, 11));
            if (r < 35) ins_valid = 1;
            else if (r < 42) inval_valid = 1;
            else if (r < 44) flush_nonglobal = 1;
            else if (r < 45) flush_all = 1;
            else if (r < 48) begin inval_valid = 1; ins_valid = 1; end
            step();
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule